// File: doc/BRIEF.md
# Serial Controller Interrupt Aggregator

This block gathers the interrupt sources of a two-channel serial controller with a counter/timer into one 8-bit interrupt status register. It also gathers changes seen on four general-purpose input pins into the same register. An 8-bit mask register selects which status bits drive the single interrupt request output. The transmit-ready and receive-ready bits mirror their sources. Each of these sources drops on its own once the CPU writes or reads the data, so acknowledging them happens in the serial datapath. The break-change and counter-ready bits latch a one-cycle event pulse, and each clears only on its own acknowledge command.

The four input pins are asynchronous to the block clock, so each one passes through a synchroniser. Any difference between two successive synchronised levels sets a sticky per-pin change flag. The change register shows these flags in its upper nibble and the current synchronised levels in its lower nibble. A read strobe on the change register clears the flags. A per-pin enable vector from the auxiliary control register decides which flags feed the input-change status bit.

Top module: `sio_irq_hub`

## Requirements
- R1: After synchronous reset, the status register, the change flags, the mask and `irq` are all zero.
- R2: Status bit 0 (channel A) and bit 4 (channel B) equal the transmit-ready input of their channel one clock after it is sampled.
- R3: Status bit 1 (A) and bit 5 (B) take one clock to follow the channel's FIFO-full input when its select input is 1, and its FIFO-not-empty input when the select is 0.
- R4: Status bit 2 (A) and bit 6 (B) are set one clock after a break event pulse of that channel. They hold until that channel's break acknowledge. When an event and an acknowledge arrive together, the bit is set. The other channel's acknowledge has no effect.
- R5: Status bit 3 is set one clock after a counter-ready pulse and cleared one clock after a counter acknowledge. Set wins when both arrive together.
- R6: Each input pin passes through a two-flop synchroniser. A level applied before clock edge k shows in change register bits 3-0 after edge k+1, and any level change sets the pin's change flag (change register bits 7-4) after edge k+2.
- R7: A change register read strobe clears all change flags at the next edge. A change detected in the same cycle as the read keeps its flag set.
- R8: Status bit 7 becomes, one clock later, the OR of the change flags ANDed with the 4-bit change-enable input. Bit n of the enable input controls pin n.
- R9: A mask write loads the mask at the next edge. `irq` is high exactly when status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| a_tx_ready | input | 1 | Channel A holding register empty |
| a_rx_nempty | input | 1 | Channel A receive FIFO not empty |
| a_rx_full | input | 1 | Channel A receive FIFO full |
| a_rx_use_full | input | 1 | Channel A mode select: 1 reports FIFO full |
| a_brk_pulse | input | 1 | Channel A break change event |
| a_brk_ack | input | 1 | Channel A break-change acknowledge command |
| b_tx_ready | input | 1 | Channel B holding register empty |
| b_rx_nempty | input | 1 | Channel B receive FIFO not empty |
| b_rx_full | input | 1 | Channel B receive FIFO full |
| b_rx_use_full | input | 1 | Channel B mode select: 1 reports FIFO full |
| b_brk_pulse | input | 1 | Channel B break change event |
| b_brk_ack | input | 1 | Channel B break-change acknowledge command |
| ctr_pulse | input | 1 | Counter ready event |
| ctr_ack | input | 1 | Counter stop (acknowledge) command |
| gp_pins | input | 4 | Asynchronous general-purpose inputs |
| chg_enable | input | 4 | Per-pin change interrupt enables |
| chg_rd | input | 1 | Change register read strobe |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| status | output | 8 | Interrupt status register |
| chg_reg | output | 8 | Change flags (7-4) and synced levels (3-0) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: four input pins and two synchroniser stages. With these values the change register fills exactly one byte, and a pin change reaches the flags three edges after it is applied. That short latency means random read strobes often land in the same cycle as a detected change, so the keep-on-clear case of R7 is hit many times. It also means random pulse traffic regularly produces event and acknowledge together on the break and counter bits.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int STAT_W = 8;

    // status bit positions; the register layout is fixed
    localparam int B_A_TX  = 0;
    localparam int B_A_RX  = 1;
    localparam int B_A_BRK = 2;
    localparam int B_CTR   = 3;
    localparam int B_B_TX  = 4;
    localparam int B_B_RX  = 5;
    localparam int B_B_BRK = 6;
    localparam int B_PIN   = 7;

    typedef struct packed {
        logic tx_ready;
        logic rx_nempty;
        logic rx_full;
        logic rx_use_full;
        logic brk_pulse;
        logic brk_ack;
    } chan_src_t;

    function automatic logic rx_pick(input chan_src_t c);
        return c.rx_use_full ? c.rx_full : c.rx_nempty;
    endfunction

    function automatic logic sticky(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic changed
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level   = chain[STAGES-1];
    assign changed = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/chg_latch.sv
module chg_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] chg_in,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= chg_in | (flags & {N{~rd_clr}});
    end
endmodule

// File: rtl/irq_core.sv
module irq_core
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_src_t         ch_a,
    input  chan_src_t         ch_b,
    input  logic              ctr_pulse,
    input  logic              ctr_ack,
    input  logic              pin_any,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        stat_d          = status;
        stat_d[B_A_TX]  = ch_a.tx_ready;
        stat_d[B_A_RX]  = rx_pick(ch_a);
        stat_d[B_A_BRK] = sticky(status[B_A_BRK], ch_a.brk_pulse, ch_a.brk_ack);
        stat_d[B_CTR]   = sticky(status[B_CTR], ctr_pulse, ctr_ack);
        stat_d[B_B_TX]  = ch_b.tx_ready;
        stat_d[B_B_RX]  = rx_pick(ch_b);
        stat_d[B_B_BRK] = sticky(status[B_B_BRK], ch_b.brk_pulse, ch_b.brk_ack);
        stat_d[B_PIN]   = pin_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask_q <= '0;
        end else begin
            status <= stat_d;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq = |(status & mask_q);
endmodule

// File: rtl/sio_irq_hub.sv
module sio_irq_hub
    import sio_irq_pkg::*;
#(
    parameter int N_PINS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_tx_ready,
    input  logic              a_rx_nempty,
    input  logic              a_rx_full,
    input  logic              a_rx_use_full,
    input  logic              a_brk_pulse,
    input  logic              a_brk_ack,
    input  logic              b_tx_ready,
    input  logic              b_rx_nempty,
    input  logic              b_rx_full,
    input  logic              b_rx_use_full,
    input  logic              b_brk_pulse,
    input  logic              b_brk_ack,
    input  logic              ctr_pulse,
    input  logic              ctr_ack,
    input  logic [N_PINS-1:0] gp_pins,
    input  logic [N_PINS-1:0] chg_enable,
    input  logic              chg_rd,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status,
    output logic [2*N_PINS-1:0] chg_reg,
    output logic              irq
);
    localparam int CHG_W = 2 * N_PINS;

    logic [N_PINS-1:0] pin_lvl;
    logic [N_PINS-1:0] pin_chg;
    logic [N_PINS-1:0] pin_flags;
    chan_src_t         src_a, src_b;

    assign src_a = '{a_tx_ready, a_rx_nempty, a_rx_full, a_rx_use_full, a_brk_pulse, a_brk_ack};
    assign src_b = '{b_tx_ready, b_rx_nempty, b_rx_full, b_rx_use_full, b_brk_pulse, b_brk_ack};

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .pin     (gp_pins[i]),
            .level   (pin_lvl[i]),
            .changed (pin_chg[i])
        );
    end

    chg_latch #(.N(N_PINS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .chg_in (pin_chg),
        .rd_clr (chg_rd),
        .flags  (pin_flags)
    );

    irq_core u_core (
        .clk        (clk),
        .rst        (rst),
        .ch_a       (src_a),
        .ch_b       (src_b),
        .ctr_pulse  (ctr_pulse),
        .ctr_ack    (ctr_ack),
        .pin_any    (|(pin_flags & chg_enable)),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .status     (status),
        .irq        (irq)
    );

    assign chg_reg[CHG_W-1:N_PINS] = pin_flags;
    assign chg_reg[N_PINS-1:0]     = pin_lvl;
endmodule

// File: rtl/sio_irq_hub_chk.sv
module sio_irq_hub_chk (
    input logic       clk,
    input logic       rst,
    input logic       a_tx_ready,
    input logic       a_brk_pulse,
    input logic       a_brk_ack,
    input logic       b_brk_ack,
    input logic       ctr_pulse,
    input logic       ctr_ack,
    input logic       chg_rd,
    input logic [3:0] pin_chg,
    input logic       mask_we,
    input logic [7:0] mask_wdata,
    input logic [7:0] status,
    input logic [7:0] chg_reg,
    input logic       irq
);
    // R2
    a_tx_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> status[0] == $past(a_tx_ready));
    // R4
    a_brk_set_chk: assert property (@(posedge clk) disable iff (rst)
        a_brk_pulse |=> status[2]);
    // R4
    a_brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status[2] && !a_brk_ack && b_brk_ack) |=> status[2]);
    // R5
    ctr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctr_ack && !ctr_pulse) |=> !status[3]);
    // R7
    chg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_rd && pin_chg == 4'b0) |=> chg_reg[7:4] == 4'b0);
    // R9
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_we && mask_wdata == 8'h00) |=> !irq);
endmodule

bind sio_irq_hub sio_irq_hub_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_tx_ready  (a_tx_ready),
    .a_brk_pulse (a_brk_pulse),
    .a_brk_ack   (a_brk_ack),
    .b_brk_ack   (b_brk_ack),
    .ctr_pulse   (ctr_pulse),
    .ctr_ack     (ctr_ack),
    .chg_rd      (chg_rd),
    .pin_chg     (pin_chg),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .status      (status),
    .chg_reg     (chg_reg),
    .irq         (irq)
);

// File: tb/test_sio_irq_hub.sv
`timescale 1ns/1ps
module test_sio_irq_hub;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_tx, a_ne, a_fu, a_sel, a_bp, a_ba;
    logic b_tx, b_ne, b_fu, b_sel, b_bp, b_ba;
    logic ctr_p, ctr_a, chg_rd, mask_we;
    logic [3:0] pins, chg_en;
    logic [7:0] mask_wd;
    logic [7:0] status, chg_reg;
    logic irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sio_irq_hub i_sio_irq_hub (
        .clk(clk), .rst(rst),
        .a_tx_ready(a_tx), .a_rx_nempty(a_ne), .a_rx_full(a_fu), .a_rx_use_full(a_sel),
        .a_brk_pulse(a_bp), .a_brk_ack(a_ba),
        .b_tx_ready(b_tx), .b_rx_nempty(b_ne), .b_rx_full(b_fu), .b_rx_use_full(b_sel),
        .b_brk_pulse(b_bp), .b_brk_ack(b_ba),
        .ctr_pulse(ctr_p), .ctr_ack(ctr_a),
        .gp_pins(pins), .chg_enable(chg_en), .chg_rd(chg_rd),
        .mask_we(mask_we), .mask_wdata(mask_wd),
        .status(status), .chg_reg(chg_reg), .irq(irq)
    );

    // reference model built from the requirements
    logic [7:0] m_stat, m_mask;
    logic [3:0] m_s1, m_s2, m_prev, m_flags;

    function automatic logic stick(input logic cur, input logic s, input logic c);
        return s | (cur & ~c);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat <= 0; m_mask <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flags <= 0;
        end else begin
            m_s1    <= pins;
            m_s2    <= m_s1;
            m_prev  <= m_s2;
            m_flags <= (m_s2 ^ m_prev) | (chg_rd ? 4'b0 : m_flags);
            m_stat  <= {|(m_flags & chg_en),
                        stick(m_stat[6], b_bp, b_ba), b_sel ? b_fu : b_ne, b_tx,
                        stick(m_stat[3], ctr_p, ctr_a),
                        stick(m_stat[2], a_bp, a_ba), a_sel ? a_fu : a_ne, a_tx};
            if (mask_we) m_mask <= mask_wd;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 tx bits",  {status[4], status[0]}, {m_stat[4], m_stat[0]});
        chk("R3 rx bits",  {status[5], status[1]}, {m_stat[5], m_stat[1]});
        chk("R4 brk bits", {status[6], status[2]}, {m_stat[6], m_stat[2]});
        chk("R5 ctr bit",  status[3], m_stat[3]);
        chk("R6 levels",   chg_reg[3:0], m_s2);
        chk("R7 flags",    chg_reg[7:4], m_flags);
        chk("R8 pin bit",  status[7], m_stat[7]);
        chk("R9 irq",      irq, |(m_stat & m_mask));
    endtask

    task automatic idle();
        {a_tx, a_ne, a_fu, a_sel, a_bp, a_ba} = 0;
        {b_tx, b_ne, b_fu, b_sel, b_bp, b_ba} = 0;
        {ctr_p, ctr_a, chg_rd, mask_we} = 0;
        pins = 0; chg_en = 0; mask_wd = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 status", status, 8'h00);
        chk("R1 chg", chg_reg, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // R4: event and ack together sets; other channel ack ignored
        a_bp = 1; a_ba = 1; step();
        chk("R4 set wins", status[2], 1'b1);
        a_bp = 0; a_ba = 0; b_ba = 1; step();
        chk("R4 other ack", status[2], 1'b1);
        b_ba = 0; a_ba = 1; step();
        chk("R4 own ack", status[2], 1'b0);
        a_ba = 0;

        // R6/R7: pin change lands on the same cycle as a read
        chg_en = 4'b0001; mask_we = 1; mask_wd = 8'h80; pins = 4'b0001;
        step(); mask_we = 0;
        step();
        chk("R6 level", chg_reg[0], 1'b1);
        chg_rd = 1; step(); chg_rd = 0;
        chk("R7 kept on read", chg_reg[4], 1'b1);
        step();
        chk("R8 pin status", status[7], 1'b1);
        chk("R9 irq from pin", irq, 1'b1);
        chg_rd = 1; step(); chg_rd = 0;
        chk("R7 cleared", chg_reg[7:4], 4'h0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            a_tx = $urandom() & 1; a_ne = $urandom() & 1; a_fu = $urandom() & 1;
            b_tx = $urandom() & 1; b_ne = $urandom() & 1; b_fu = $urandom() & 1;
            if ($urandom_range(0, 15) == 0) a_sel = ~a_sel;
            if ($urandom_range(0, 15) == 0) b_sel = ~b_sel;
            a_bp  = ($urandom_range(0, 7) == 0); a_ba = ($urandom_range(0, 7) == 0);
            b_bp  = ($urandom_range(0, 7) == 0); b_ba = ($urandom_range(0, 7) == 0);
            ctr_p = ($urandom_range(0, 7) == 0); ctr_a = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 3) == 0) pins = 4'($urandom());
            if ($urandom_range(0, 31) == 0) chg_en = 4'($urandom());
            chg_rd  = ($urandom_range(0, 3) == 0);
            mask_we = ($urandom_range(0, 15) == 0);
            mask_wd = 8'($urandom());
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule